// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

The monitor serves a few hardware threads that share one word-addressed memory. Each thread can issue a plain load, a plain store, a load-reserved or a store-conditional in any cycle. It can also raise a flush strobe when it takes an exception or switches context. A load-reserved returns the current data and leaves a reservation for that thread. A later store-conditional to the same address writes only if no write of any kind has touched the reserved 64-byte line in between. Because of this, a value that was changed and then restored still makes the store-conditional fail, and the block is immune to the ABA problem.

All requests that arrive in one cycle are handled in a fixed thread order, lowest index first. Each later thread sees the writes and reservation losses caused by the earlier ones. Every request gets a response exactly one cycle later. For a store-conditional the result is 0 on success and 1 on failure. A double-width variant works on an even-aligned word pair under the same rules.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, memory reads as zero, no thread holds a reservation and `rsp_valid_o` is low.
- R2: Op codes on `req_op_i` are 0 load, 1 store, 2 load-reserved and 3 store-conditional. A request in cycle n gives `rsp_valid_o` high in cycle n+1. A single load or load-reserved returns the word zero-extended, a store writes the word and responds 0, and addresses are word addresses.
- R3: A store-conditional whose thread holds a reservation for that exact word address, with no write to the line since, writes memory and responds 0.
- R4: A store-conditional with no reservation, or with an address other than the one of its thread's last load-reserved, responds 1 and leaves memory unchanged.
- R5: A line is word-address bits [6:4] (64 bytes of 4-byte words). Any write that lands in a line clears every reservation on that line, and a write to another line clears none of them.
- R6: A store-conditional fails after an intervening write even when the data has since been put back to the reserved value.
- R7: A new load-reserved replaces the thread's previous reservation.
- R8: `flush_i` clears that thread's reservation. When it comes with a request in the same cycle, the flush acts first.
- R9: A store-conditional clears its own thread's reservation whether it succeeds or fails.
- R10: With `req_dbl_i` set, bit 0 of the address is ignored. Reads return {word at addr|1, word at addr&~1} across 64 bits, and stores and store-conditionals write both words under the same rules.
- R11: Requests in one cycle act in order from thread 0 upward. A later thread sees an earlier thread's writes in its read data and loses any reservation that an earlier write in that cycle cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_THREADS | Request strobe per thread |
| req_op_i | input | 2*NUM_THREADS | Op code per thread |
| req_dbl_i | input | NUM_THREADS | Double-width operand per thread |
| req_waddr_i | input | WADDR_W*NUM_THREADS | Word address per thread |
| req_wdata_i | input | 2*DATA_W*NUM_THREADS | Write data per thread, high word used only when double |
| flush_i | input | NUM_THREADS | Exception or context switch, drops the thread's reservation |
| rsp_valid_o | output | NUM_THREADS | Response strobe per thread |
| rsp_rdata_o | output | 2*DATA_W*NUM_THREADS | Read data, or the store-conditional result in bit 0 |

## Verification
The bench goes after the ABA pattern: a design that compares data instead of tracking writes would let that store-conditional succeed. It also covers a write to a different word of the reserved line, which a design tracking single words would miss, and a write to the next line, which a design with too coarse a line would wrongly count. Same-cycle pairs test the ordering. Two store-conditionals to one line must give exactly one winner, and a load that comes after a store in the same cycle must return the new data. A wrong order or missing forwarding would produce two successes or stale data. Flush together with load-reserved, a replaced reservation and a retried store-conditional each catch a wrong update order or a reservation that survives too long.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LR    = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_resv_chain.sv
module llsc_resv_chain
  import llsc_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int WADDR_W     = 7,
  parameter int LINE_SH     = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic     [NUM_THREADS-1:0]          valid_i,
  input  logic     [NUM_THREADS-1:0]          flush_i,
  input  llsc_op_e [NUM_THREADS-1:0]          op_i,
  input  logic     [NUM_THREADS-1:0][WADDR_W-1:0] waddr_i,
  output logic     [NUM_THREADS-1:0]          wr_en_o,
  output logic     [NUM_THREADS-1:0]          sc_fail_o
);
  logic [NUM_THREADS-1:0]              res_valid_q, rv;
  logic [NUM_THREADS-1:0][WADDR_W-1:0] res_addr_q, ra;
  logic [NUM_THREADS-1:0]              wr, fail;

  // threads walk in priority order; each sees the updates of those before it
  always_comb begin
    rv   = res_valid_q;
    ra   = res_addr_q;
    wr   = '0;
    fail = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (flush_i[i]) rv[i] = 1'b0;
      if (valid_i[i]) begin
        unique case (op_i[i])
          OP_LR: begin
            rv[i] = 1'b1;
            ra[i] = waddr_i[i];
          end
          OP_STORE: wr[i] = 1'b1;
          OP_SC: begin
            if (rv[i] && ra[i] == waddr_i[i]) wr[i] = 1'b1;
            else                               fail[i] = 1'b1;
            rv[i] = 1'b0;
          end
          default: ;
        endcase
        if (wr[i]) begin
          for (int j = 0; j < NUM_THREADS; j++) begin
            if (ra[j][WADDR_W-1:LINE_SH] == waddr_i[i][WADDR_W-1:LINE_SH]) rv[j] = 1'b0;
          end
        end
      end
    end
  end

  assign wr_en_o   = wr;
  assign sc_fail_o = fail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= '0;
      res_addr_q  <= '0;
    end else begin
      res_valid_q <= rv;
      res_addr_q  <= ra;
    end
  end

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
    p_sc_clears_own_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[g] && op_i[g] == OP_SC) |=> !res_valid_q[g]);
    p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_i[g] && !(valid_i[g] && op_i[g] == OP_LR)) |=> !res_valid_q[g]);
    p_sc_needs_resv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[g] && op_i[g] == OP_SC && !res_valid_q[g]) |-> sc_fail_o[g]);
    p_lr_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[g] && op_i[g] == OP_LR && $countones(valid_i) == 1)
      |=> (res_valid_q[g] && res_addr_q[g] == $past(waddr_i[g])));
  end
endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int NUM_THREADS = 2,
  parameter int WADDR_W     = 7,
  parameter int DATA_W      = 32
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [NUM_THREADS-1:0]                 wr_en_i,
  input  logic [NUM_THREADS-1:0]                 dbl_i,
  input  logic [NUM_THREADS-1:0][WADDR_W-1:0]    waddr_i,
  input  logic [NUM_THREADS-1:0][2*DATA_W-1:0]   wdata_i,
  output logic [NUM_THREADS-1:0][2*DATA_W-1:0]   rdata_o
);
  localparam int DEPTH = 2 ** WADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // word value as seen by thread 'upto' after all higher-priority writes this cycle
  function automatic logic [DATA_W-1:0] peek(input logic [WADDR_W-1:0] w, input int upto);
    logic [DATA_W-1:0] v;
    v = mem_q[w];
    for (int j = 0; j < upto; j++) begin
      if (wr_en_i[j]) begin
        if (waddr_i[j] == w) v = wdata_i[j][DATA_W-1:0];
        if (dbl_i[j] && (waddr_i[j] | WADDR_W'(1)) == w) v = wdata_i[j][2*DATA_W-1:DATA_W];
      end
    end
    return v;
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      rdata_o[i][DATA_W-1:0]        = peek(waddr_i[i], i);
      rdata_o[i][2*DATA_W-1:DATA_W] = dbl_i[i] ? peek(waddr_i[i] | WADDR_W'(1), i) : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (wr_en_i[i]) begin
          mem_q[waddr_i[i]] <= wdata_i[i][DATA_W-1:0];
          if (dbl_i[i]) mem_q[waddr_i[i] | WADDR_W'(1)] <= wdata_i[i][2*DATA_W-1:DATA_W];
        end
      end
    end
  end

  // lowest-priority thread has the final say on any word it writes
  p_last_write_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[NUM_THREADS-1]
    |=> mem_q[$past(waddr_i[NUM_THREADS-1])] == $past(wdata_i[NUM_THREADS-1][DATA_W-1:0]));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int WADDR_W     = 7,
  parameter int DATA_W      = 32,
  parameter int LINE_BYTES  = 64
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_THREADS-1:0]            req_valid_i,
  input  logic [2*NUM_THREADS-1:0]          req_op_i,
  input  logic [NUM_THREADS-1:0]            req_dbl_i,
  input  logic [WADDR_W*NUM_THREADS-1:0]    req_waddr_i,
  input  logic [2*DATA_W*NUM_THREADS-1:0]   req_wdata_i,
  input  logic [NUM_THREADS-1:0]            flush_i,
  output logic [NUM_THREADS-1:0]            rsp_valid_o,
  output logic [2*DATA_W*NUM_THREADS-1:0]   rsp_rdata_o
);
  localparam int LINE_SH = $clog2(LINE_BYTES) - $clog2(DATA_W / 8);
  localparam int RW      = 2 * DATA_W;

  llsc_op_e [NUM_THREADS-1:0]              op;
  logic     [NUM_THREADS-1:0][WADDR_W-1:0] waddr;
  logic     [NUM_THREADS-1:0][RW-1:0]      wdata, rdata, rsp_d, rsp_q;
  logic     [NUM_THREADS-1:0]              wr_en, sc_fail;
  logic     [NUM_THREADS-1:0]              rsp_valid_q;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_dec
    assign op[g]    = llsc_op_e'(req_op_i[2*g +: 2]);
    assign waddr[g] = req_waddr_i[WADDR_W*g +: WADDR_W] & ~WADDR_W'(req_dbl_i[g]);
    assign wdata[g] = req_wdata_i[RW*g +: RW];
  end

  llsc_resv_chain #(
    .NUM_THREADS(NUM_THREADS),
    .WADDR_W    (WADDR_W),
    .LINE_SH    (LINE_SH)
  ) u_resv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .flush_i  (flush_i),
    .op_i     (op),
    .waddr_i  (waddr),
    .wr_en_o  (wr_en),
    .sc_fail_o(sc_fail)
  );

  llsc_word_mem #(
    .NUM_THREADS(NUM_THREADS),
    .WADDR_W    (WADDR_W),
    .DATA_W     (DATA_W)
  ) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en),
    .dbl_i  (req_dbl_i),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      unique case (op[i])
        OP_LOAD, OP_LR: rsp_d[i] = rdata[i];
        OP_SC:          rsp_d[i] = RW'(sc_fail[i]);
        default:        rsp_d[i] = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_q       <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      for (int i = 0; i < NUM_THREADS; i++) begin
        if (req_valid_i[i]) rsp_q[i] <= rsp_d[i];
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_q;

  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rsp_valid_o == $past(req_valid_i));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
    p_sc_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i[g] && op[g] == OP_SC) |=> rsp_rdata_o[RW*g+1 +: RW-1] == '0);
  end
endmodule

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
  localparam int NT = 2;
  localparam int AW = 7;
  localparam int DW = 32;
  localparam int RW = 2 * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NT-1:0]    req_valid = '0;
  logic [2*NT-1:0]  req_op = '0;
  logic [NT-1:0]    req_dbl = '0;
  logic [AW*NT-1:0] req_waddr = '0;
  logic [RW*NT-1:0] req_wdata = '0;
  logic [NT-1:0]    flush = '0;
  logic [NT-1:0]    rsp_valid;
  logic [RW*NT-1:0] rsp_rdata;

  llsc_monitor #(.NUM_THREADS(NT), .WADDR_W(AW), .DATA_W(DW), .LINE_BYTES(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_dbl_i(req_dbl), .req_waddr_i(req_waddr), .req_wdata_i(req_wdata),
    .flush_i(flush), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata));

  int checks = 0;
  int errors = 0;

  // reference state
  logic [DW-1:0] m_mem [2**AW];
  bit            m_rv  [NT];
  logic [AW-1:0] m_ra  [NT];

  // stimulus and expectations
  bit            s_v [NT];
  bit            s_dbl [NT];
  bit            s_fl [NT];
  logic [1:0]    s_op [NT];
  logic [AW-1:0] s_a [NT];
  logic [RW-1:0] s_wd [NT];
  bit            e_v [NT];
  logic [RW-1:0] e_d [NT];
  string         e_tag [NT];

  function automatic string op_tag(logic [1:0] op, bit dbl, bit fail);
    if (dbl) return "R10";
    if (op == 2'd3) return fail ? "R4" : "R3";
    return "R2";
  endfunction

  task automatic clear_stim();
    for (int i = 0; i < NT; i++) begin
      s_v[i] = 0; s_dbl[i] = 0; s_fl[i] = 0; s_op[i] = '0; s_a[i] = '0; s_wd[i] = '0;
    end
    req_valid = '0;
    flush     = '0;
  endtask

  task automatic set_req(int t, logic [1:0] op, bit dbl, logic [AW-1:0] a, logic [RW-1:0] wd);
    s_v[t] = 1; s_op[t] = op; s_dbl[t] = dbl; s_a[t] = a; s_wd[t] = wd;
  endtask

  task automatic model_and_drive(string tag);
    for (int i = 0; i < NT; i++) begin
      req_valid[i]          = s_v[i];
      req_op[2*i +: 2]      = s_op[i];
      req_dbl[i]            = s_dbl[i];
      req_waddr[AW*i +: AW] = s_a[i];
      req_wdata[RW*i +: RW] = s_wd[i];
      flush[i]              = s_fl[i];
    end
    for (int i = 0; i < NT; i++) begin
      logic [AW-1:0] w;
      bit wr, fail;
      wr = 0; fail = 0;
      if (s_fl[i]) m_rv[i] = 0;
      e_v[i] = s_v[i];
      e_d[i] = '0;
      w = s_dbl[i] ? (s_a[i] & ~AW'(1)) : s_a[i];
      if (s_v[i]) begin
        case (s_op[i])
          2'd0, 2'd2: begin
            e_d[i] = s_dbl[i] ? {m_mem[w | AW'(1)], m_mem[w]} : {{DW{1'b0}}, m_mem[w]};
            if (s_op[i] == 2'd2) begin m_rv[i] = 1; m_ra[i] = w; end
          end
          2'd1: wr = 1;
          default: begin
            if (m_rv[i] && m_ra[i] == w) wr = 1;
            else begin fail = 1; e_d[i] = RW'(1); end
            m_rv[i] = 0;
          end
        endcase
        if (wr) begin
          m_mem[w] = s_wd[i][DW-1:0];
          if (s_dbl[i]) m_mem[w | AW'(1)] = s_wd[i][RW-1:DW];
          for (int j = 0; j < NT; j++)
            if (m_ra[j][AW-1:4] == w[AW-1:4]) m_rv[j] = 0;
        end
      end
      e_tag[i] = (tag != "") ? tag : op_tag(s_op[i], s_dbl[i], fail);
    end
  endtask

  // called at a negedge; response is checked at the next negedge
  task automatic run(string tag);
    model_and_drive(tag);
    @(negedge clk);
    for (int i = 0; i < NT; i++) begin
      checks++;
      if (rsp_valid[i] !== e_v[i] || (e_v[i] && rsp_rdata[RW*i +: RW] !== e_d[i])) begin
        errors++;
        $display("FAIL %s thread %0d: valid %0b data %h, expected valid %0b data %h",
                 e_tag[i], i, rsp_valid[i], rsp_rdata[RW*i +: RW], e_v[i], e_d[i]);
      end
    end
    clear_stim();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 2**AW; k++) m_mem[k] = '0;
    for (int i = 0; i < NT; i++) begin m_rv[i] = 0; m_ra[i] = '0; end
    clear_stim();
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== '0) begin
      errors++;
      $display("FAIL R1: rsp_valid %b in reset, expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle, zero memory, no reservation
    run("R1");
    set_req(0, 2'd0, 0, 7'h00, '0); set_req(1, 2'd0, 1, 7'h7e, '0); run("R1");
    set_req(0, 2'd3, 0, 7'h00, 64'h1); run("R1");

    // R3 basic success, then R9 retry fails
    set_req(0, 2'd2, 0, 7'h10, '0); run("R3");
    set_req(0, 2'd3, 0, 7'h10, 64'h11); run("R3");
    set_req(0, 2'd0, 0, 7'h10, '0); run("R3");
    set_req(0, 2'd3, 0, 7'h10, 64'h22); run("R9");
    set_req(0, 2'd0, 0, 7'h10, '0); run("R9");

    // R5 other word of same line clears, next line does not
    set_req(0, 2'd2, 0, 7'h20, '0); run("R5");
    set_req(1, 2'd1, 0, 7'h2f, 64'h7); run("R5");
    set_req(0, 2'd3, 0, 7'h20, 64'h33); run("R5");
    set_req(0, 2'd0, 0, 7'h20, '0); run("R5");
    set_req(0, 2'd2, 0, 7'h20, '0); run("R5");
    set_req(1, 2'd1, 0, 7'h30, 64'h8); run("R5");
    set_req(0, 2'd3, 0, 7'h20, 64'h44); run("R5");

    // R6 ABA
    set_req(0, 2'd2, 0, 7'h40, '0); run("R6");
    set_req(1, 2'd1, 0, 7'h40, 64'h5); run("R6");
    set_req(1, 2'd1, 0, 7'h40, 64'h0); run("R6");
    set_req(0, 2'd3, 0, 7'h40, 64'h9); run("R6");
    set_req(0, 2'd0, 0, 7'h40, '0); run("R6");

    // R7 replace, R4 address mismatch
    set_req(0, 2'd2, 0, 7'h11, '0); run("R7");
    set_req(0, 2'd2, 0, 7'h12, '0); run("R7");
    set_req(0, 2'd3, 0, 7'h11, 64'h66); run("R7");
    set_req(0, 2'd2, 0, 7'h11, '0); run("R7");
    set_req(0, 2'd2, 0, 7'h12, '0); run("R7");
    set_req(0, 2'd3, 0, 7'h12, 64'h77); run("R7");
    set_req(0, 2'd2, 0, 7'h13, '0); run("R4");
    set_req(0, 2'd3, 0, 7'h14, 64'h88); run("R4");
    set_req(0, 2'd0, 0, 7'h14, '0); run("R4");

    // R8 flush alone, then flush with load-reserved
    set_req(1, 2'd2, 0, 7'h50, '0); run("R8");
    s_fl[1] = 1; run("R8");
    set_req(1, 2'd3, 0, 7'h50, 64'h99); run("R8");
    s_fl[1] = 1; set_req(1, 2'd2, 0, 7'h50, '0); run("R8");
    set_req(1, 2'd3, 0, 7'h50, 64'haa); run("R8");

    // R10 double width
    set_req(0, 2'd1, 1, 7'h60, 64'haaaa_0001_bbbb_0002); run("R10");
    set_req(0, 2'd0, 0, 7'h61, '0); set_req(1, 2'd0, 0, 7'h60, '0); run("R10");
    set_req(0, 2'd2, 1, 7'h61, '0); run("R10");
    set_req(0, 2'd3, 1, 7'h60, 64'hcccc_0003_dddd_0004); run("R10");
    set_req(1, 2'd0, 1, 7'h60, '0); run("R10");

    // R11 same-cycle ordering
    set_req(0, 2'd2, 0, 7'h70, '0); set_req(1, 2'd2, 0, 7'h72, '0); run("R11");
    set_req(0, 2'd3, 0, 7'h70, 64'h1); set_req(1, 2'd3, 0, 7'h72, 64'h2); run("R11");
    set_req(0, 2'd1, 0, 7'h74, 64'h55); set_req(1, 2'd0, 0, 7'h74, '0); run("R11");
    set_req(0, 2'd2, 0, 7'h76, '0); run("R11");
    set_req(0, 2'd0, 0, 7'h76, '0); set_req(1, 2'd1, 0, 7'h7a, 64'h3); run("R11");
    set_req(0, 2'd3, 0, 7'h76, 64'h4); run("R11");

    // random mix over two lines, small data values to provoke ABA
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < NT; i++) begin
        s_v[i]   = ($urandom % 4) != 0;
        s_op[i]  = 2'($urandom % 4);
        s_dbl[i] = ($urandom % 5) == 0;
        s_a[i]   = AW'((5 + $urandom % 2) * 16 + $urandom % 4);
        s_wd[i]  = {32'($urandom % 3), 32'($urandom % 3)};
        s_fl[i]  = ($urandom % 16) == 0;
      end
      run("");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule